// File: doc/BRIEF.md
# Transmit Statistics Counter Bank

This block keeps three transmit-side statistics counters for an Ethernet MAC: frames sent after exactly one collision, frames sent after several collisions, and frames dropped because the transmit buffer ran dry (underrun). The transmitter raises a one-cycle pulse for each such frame. Software reads each counter through a small 32-bit register port. A read returns the count and clears the counter in the same access. A counter that reaches its largest value stays there instead of wrapping.

Two control bits let test software drive the bank directly. The first is the test write enable, bit 7 of the MAC network control register. It makes the counters writable through the register port. The second is increment-all, bit 6 of the same register. It adds one to every counter in each cycle it is high. An underrun pulse takes priority over the collision pulses in the same cycle. An underrun frame is counted only as an underrun, never as a collision frame.

Top module: `txstat_bank`

## Requirements
- R1: After reset, all three counters read as zero.
- R2: The single-collision counter is 18 bits wide at byte offset 0x138 and occupies read bits 17:0. Read bits 31:18 are always zero. It adds one per `ev_scol` pulse.
- R3: The multi-collision counter is 18 bits wide at byte offset 0x13C and occupies read bits 17:0. It adds one per `ev_mcol` pulse.
- R4: The underrun counter is 10 bits wide at byte offset 0x134 and occupies read bits 9:0. It adds one per `ev_urun` pulse. In a cycle with `ev_urun` high, `ev_scol` and `ev_mcol` are ignored.
- R5: `reg_rd` high at an edge loads `reg_rdata` with the addressed counter's value from before that edge. `reg_rdata` shows this value from the next cycle and holds it until the next read. The same edge clears that counter. A read of any other offset returns zero.
- R6: A counter at all ones stays at all ones on further increments.
- R7: If an increment reaches a counter in the cycle it is read, the read returns the old value and the counter becomes 1.
- R8: When `reg_wr` and `ctl_test_we` are both high, the addressed counter loads the low bits of `reg_wdata`. The bits above the counter's width are dropped. With `ctl_test_we` low, a write changes nothing.
- R9: Each cycle that `ctl_inc_all` is high adds one to every counter, with saturation applied. A counter gains at most one per cycle, even when its own event pulse arrives in the same cycle.
- R10: A test write takes precedence over events, increment-all and a read of the same counter in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_scol | input | 1 | Pulse: frame sent after exactly one collision |
| ev_mcol | input | 1 | Pulse: frame sent after 2 to 15 collisions |
| ev_urun | input | 1 | Pulse: frame aborted by transmit underrun |
| ctl_test_we | input | 1 | Network control bit 7: counters writable |
| ctl_inc_all | input | 1 | Network control bit 6: increment every counter |
| reg_addr | input | 12 | Byte offset of the access |
| reg_rd | input | 1 | Read strobe (read-and-clear) |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |

## Verification
The bench sweeps all sixteen combinations of the three event pulses and increment-all. It applies each combination a different number of times, so that a wrong gating term shows up as a wrong count in exactly one counter. It checks that an underrun masks the collision pulses and that several sources in one cycle add only one. Test writes just below full, together with a long run of underrun pulses, push each width across its saturation point. Reads that coincide with events, and writes that coincide with events or reads, separate the priorities among load, clear and increment.

// File: rtl/txstat_pkg.sv
package txstat_pkg;
  localparam int NUM_CNT = 3;
  localparam int IDX_SCOL = 0;
  localparam int IDX_MCOL = 1;
  localparam int IDX_URUN = 2;

  // Qualify the raw transmit pulses: an underrun frame counts nowhere else.
  function automatic logic [NUM_CNT-1:0] qualify_events(
    input logic scol, input logic mcol, input logic urun, input logic inc_all);
    logic [NUM_CNT-1:0] q;
    q[IDX_SCOL] = (scol & ~urun) | inc_all;
    q[IDX_MCOL] = (mcol & ~urun) | inc_all;
    q[IDX_URUN] = urun | inc_all;
    return q;
  endfunction
endpackage

// File: rtl/txstat_decode.sv
module txstat_decode #(
  parameter int ADDR_W   = 12,
  parameter int OFF_SCOL = 'h138,
  parameter int OFF_MCOL = 'h13C,
  parameter int OFF_URUN = 'h134
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [2:0]        hit
);
  always_comb begin
    hit = '0;
    hit[txstat_pkg::IDX_SCOL] = (addr == ADDR_W'(OFF_SCOL));
    hit[txstat_pkg::IDX_MCOL] = (addr == ADDR_W'(OFF_MCOL));
    hit[txstat_pkg::IDX_URUN] = (addr == ADDR_W'(OFF_URUN));
  end
endmodule

// File: rtl/txstat_counter.sv
module txstat_counter #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         clear,
  input  logic         bump,
  output logic [W-1:0] value
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  function automatic logic [W-1:0] sat_step(input logic [W-1:0] v);
    return (&v) ? v : v + W'(1);
  endfunction

  // Priority: test load, then read-clear (keeping a same-cycle bump), then bump.
  always_comb begin
    if (load)       cnt_d = load_val;
    else if (clear) cnt_d = bump ? W'(1) : '0;
    else if (bump)  cnt_d = sat_step(cnt_q);
    else            cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign value = cnt_q;
endmodule

// File: rtl/txstat_bank.sv
module txstat_bank #(
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 32,
  parameter int SCOL_W   = 18,
  parameter int MCOL_W   = 18,
  parameter int URUN_W   = 10,
  parameter int OFF_SCOL = 'h138,
  parameter int OFF_MCOL = 'h13C,
  parameter int OFF_URUN = 'h134
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_scol,
  input  logic              ev_mcol,
  input  logic              ev_urun,
  input  logic              ctl_test_we,
  input  logic              ctl_inc_all,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata
);
  import txstat_pkg::*;

  logic [NUM_CNT-1:0] addr_hit;
  logic [NUM_CNT-1:0] rd_hit;
  logic [NUM_CNT-1:0] wr_load;
  logic [NUM_CNT-1:0] bump_vec;
  logic [DATA_W-1:0]  cnt_pad [NUM_CNT];
  logic [DATA_W-1:0]  rd_mux;
  logic [SCOL_W-1:0]  cnt_scol;
  logic [MCOL_W-1:0]  cnt_mcol;
  logic [URUN_W-1:0]  cnt_urun;

  txstat_decode #(
    .ADDR_W(ADDR_W), .OFF_SCOL(OFF_SCOL), .OFF_MCOL(OFF_MCOL), .OFF_URUN(OFF_URUN)
  ) u_decode (
    .addr(reg_addr),
    .hit (addr_hit)
  );

  assign rd_hit   = addr_hit & {NUM_CNT{reg_rd}};
  assign wr_load  = addr_hit & {NUM_CNT{reg_wr & ctl_test_we}};
  assign bump_vec = qualify_events(ev_scol, ev_mcol, ev_urun, ctl_inc_all);

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    localparam int CW = (i == IDX_URUN) ? URUN_W : ((i == IDX_MCOL) ? MCOL_W : SCOL_W);
    logic [CW-1:0] val;
    txstat_counter #(.W(CW)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (wr_load[i]),
      .load_val(reg_wdata[CW-1:0]),
      .clear   (rd_hit[i]),
      .bump    (bump_vec[i]),
      .value   (val)
    );
    assign cnt_pad[i] = DATA_W'(val);
  end

  assign cnt_scol = g_cnt[IDX_SCOL].val;
  assign cnt_mcol = g_cnt[IDX_MCOL].val;
  assign cnt_urun = g_cnt[IDX_URUN].val;

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_CNT; i++)
      if (addr_hit[i]) rd_mux = rd_mux | cnt_pad[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end
endmodule

// File: rtl/txstat_bank_chk.sv
module txstat_bank_chk #(
  parameter int DATA_W = 32,
  parameter int SCOL_W = 18,
  parameter int MCOL_W = 18,
  parameter int URUN_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ev_urun,
  input logic              ctl_inc_all,
  input logic              ctl_test_we,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [2:0]        rd_hit,
  input logic [2:0]        wr_load,
  input logic [2:0]        bump_vec,
  input logic [SCOL_W-1:0] cnt_scol,
  input logic [MCOL_W-1:0] cnt_mcol,
  input logic [URUN_W-1:0] cnt_urun,
  input logic [DATA_W-1:0] reg_rdata
);
  AST_RDATA_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[DATA_W-1:SCOL_W] == '0); // R2

  AST_URUN_MASKS_SCOL: assert property (@(posedge clk) disable iff (!rst_n)
    ev_urun && !ctl_inc_all && !rd_hit[0] && !wr_load[0] |=> $stable(cnt_scol)); // R4

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit[1] && !wr_load[1] && !bump_vec[1] |=> cnt_mcol == '0); // R5

  AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (&cnt_urun) && !rd_hit[2] && !wr_load[2] |=> (&cnt_urun)); // R6

  AST_READ_EVENT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit[0] && bump_vec[0] && !wr_load[0] |=> cnt_scol == SCOL_W'(1)); // R7

  AST_WRITE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && !ctl_test_we && !reg_rd && bump_vec == '0
    |=> $stable(cnt_scol) && $stable(cnt_mcol) && $stable(cnt_urun)); // R8

  AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    bump_vec[1] && !rd_hit[1] && !wr_load[1] && !(&cnt_mcol)
    |=> cnt_mcol == $past(cnt_mcol) + MCOL_W'(1)); // R9

  AST_ONE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_load)); // R10
endmodule

bind txstat_bank txstat_bank_chk #(
  .DATA_W(DATA_W), .SCOL_W(SCOL_W), .MCOL_W(MCOL_W), .URUN_W(URUN_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_urun(ev_urun), .ctl_inc_all(ctl_inc_all),
  .ctl_test_we(ctl_test_we), .reg_wr(reg_wr), .reg_rd(reg_rd),
  .rd_hit(rd_hit), .wr_load(wr_load), .bump_vec(bump_vec),
  .cnt_scol(cnt_scol), .cnt_mcol(cnt_mcol), .cnt_urun(cnt_urun),
  .reg_rdata(reg_rdata)
);

// File: tb/txstat_bank_test.sv
module txstat_bank_test;
  localparam logic [11:0] A_SCOL = 12'h138;
  localparam logic [11:0] A_MCOL = 12'h13C;
  localparam logic [11:0] A_URUN = 12'h134;

  logic clk = 0, rst_n = 0;
  logic ev_scol = 0, ev_mcol = 0, ev_urun = 0, ctl_test_we = 0, ctl_inc_all = 0;
  logic [11:0] reg_addr = 0;
  logic reg_rd = 0, reg_wr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;

  int errors = 0, checks = 0;
  bit done = 0;
  longint exp_cnt [3];
  longint exp_rd;

  always #5 clk = ~clk;

  txstat_bank uut (
    .clk(clk), .rst_n(rst_n), .ev_scol(ev_scol), .ev_mcol(ev_mcol), .ev_urun(ev_urun),
    .ctl_test_we(ctl_test_we), .ctl_inc_all(ctl_inc_all), .reg_addr(reg_addr),
    .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  function automatic longint cap(int k);
    return (k == 2) ? 1023 : 262143;
  endfunction

  function automatic logic [11:0] off(int k);
    return (k == 0) ? A_SCOL : ((k == 1) ? A_MCOL : A_URUN);
  endfunction

  task automatic check(input longint act, input longint exp, input string req);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // One clock with the given inputs; the bench model follows the requirements.
  task automatic step(input bit s, m, u, inc, rd, wr, we,
                      input logic [11:0] a, input logic [31:0] wd);
    ev_scol = s; ev_mcol = m; ev_urun = u; ctl_inc_all = inc;
    reg_rd = rd; reg_wr = wr; ctl_test_we = we; reg_addr = a; reg_wdata = wd;
    if (rd) exp_rd = 0;
    for (int k = 0; k < 3; k++) begin
      bit hit = (a == off(k));
      bit ev = (k == 0) ? (s && !u) : ((k == 1) ? (m && !u) : u);
      bit bmp = ev || inc;
      if (rd && hit) exp_rd = exp_cnt[k];
      if (wr && we && hit)  exp_cnt[k] = longint'(wd) % (cap(k) + 1);
      else if (rd && hit)   exp_cnt[k] = bmp ? 1 : 0;
      else if (bmp)         exp_cnt[k] = (exp_cnt[k] + 1 > cap(k)) ? cap(k) : exp_cnt[k] + 1;
    end
    @(negedge clk);
    ev_scol = 0; ev_mcol = 0; ev_urun = 0; ctl_inc_all = 0;
    reg_rd = 0; reg_wr = 0; ctl_test_we = 0;
  endtask

  task automatic ev(input bit s, m, u, inc);
    step(s, m, u, inc, 0, 0, 0, 12'h0, 0);
  endtask

  task automatic rd_chk(input logic [11:0] a, input longint lit, input string req);
    step(0, 0, 0, 0, 1, 0, 0, a, 0);
    check(reg_rdata, lit, req);
  endtask

  task automatic twrite(input logic [11:0] a, input logic [31:0] wd);
    step(0, 0, 0, 0, 0, 1, 1, a, wd);
  endtask

  initial begin
    for (int k = 0; k < 3; k++) exp_cnt[k] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1: reset state
    check(reg_rdata, 0, "R1 rdata after reset");
    rd_chk(A_SCOL, 0, "R1 scol");
    rd_chk(A_MCOL, 0, "R1 mcol");
    rd_chk(A_URUN, 0, "R1 urun");

    // Sweep all 16 pulse combinations, pattern p applied p+1 times (R2 R3 R4 R9)
    for (int p = 0; p < 16; p++)
      for (int n = 0; n <= p; n++) ev(p[0], p[1], p[2], p[3]);
    // arithmetic expectation: scol bumps when (s&!u)|inc, etc.
    begin
      longint es = 0, em = 0, eu = 0;
      for (int p = 0; p < 16; p++) begin
        if ((p[0] && !p[2]) || p[3]) es += p + 1;
        if ((p[1] && !p[2]) || p[3]) em += p + 1;
        if (p[2] || p[3])            eu += p + 1;
      end
      rd_chk(A_SCOL, es, "R2 sweep scol count");
      rd_chk(A_MCOL, em, "R3 sweep mcol count");
      rd_chk(A_URUN, eu, "R4 sweep urun count (underrun masks collisions)");
    end
    rd_chk(A_SCOL, 0, "R5 scol cleared by read");
    rd_chk(A_URUN, 0, "R5 urun cleared by read");
    rd_chk(12'h140, 0, "R5 unmapped offset");
    rd_chk(12'h000, 0, "R5 unmapped offset zero");

    // R8 test writes, upper bits dropped
    twrite(A_SCOL, 32'hFFFF_FFFF);
    rd_chk(A_SCOL, 32'h0003_FFFF, "R8 R2 scol write truncated");
    twrite(A_URUN, 32'h0000_1234);
    rd_chk(A_URUN, 32'h0000_0234, "R8 urun write truncated");
    step(0, 0, 0, 0, 0, 1, 0, A_MCOL, 32'h55);
    rd_chk(A_MCOL, 0, "R8 write without enable ignored");

    // R6 saturation
    twrite(A_MCOL, 32'h3_FFFE);
    ev(0, 1, 0, 0); ev(0, 1, 0, 0); ev(0, 1, 0, 0);
    rd_chk(A_MCOL, 32'h3_FFFF, "R6 mcol saturates");
    for (int n = 0; n < 1030; n++) ev(0, 0, 1, 0);
    rd_chk(A_URUN, 1023, "R6 urun saturates");

    // R7 read coinciding with event
    for (int n = 0; n < 5; n++) ev(1, 0, 0, 0);
    step(1, 0, 0, 0, 1, 0, 0, A_SCOL, 0);
    check(reg_rdata, 5, "R7 read returns old value");
    rd_chk(A_SCOL, 1, "R7 event kept after read");

    // R9 held increment-all and one-per-cycle rule
    for (int n = 0; n < 7; n++) ev(0, 0, 0, 1);
    ev(1, 1, 1, 1);
    rd_chk(A_SCOL, 8, "R9 scol inc-all held");
    rd_chk(A_MCOL, 8, "R9 mcol inc-all held");
    rd_chk(A_URUN, 8, "R9 urun inc-all held");

    // R10 write beats event, increment-all and read
    step(0, 0, 1, 1, 0, 1, 1, A_URUN, 100);
    rd_chk(A_URUN, 100, "R10 write beats event");
    step(1, 0, 0, 0, 1, 1, 1, A_SCOL, 77);
    rd_chk(A_SCOL, 77, "R10 write beats read");
    check(exp_cnt[1], 1, "R10 model side counter");
    rd_chk(A_MCOL, exp_cnt[1], "R10 mcol bumped only by inc");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule